// File: doc/BRIEF.md
# Indirect Command/Status Bus Access Bridge

This block lets software reach a 32-bit peripheral bus through a small window of 64-bit registers. Software first loads a data register, then writes a control word that names the target address, the number of bytes and whether the access is a read. The bridge runs exactly one transfer on the peripheral bus. When the bus answers with ready or error, the bridge posts the outcome in a status register. Reading that status register returns the value once and then clears it.

Register accesses are 8 bytes wide and use big-endian byte order, so byte 0 of a register is bits 63:56. The register is chosen by address bits [4:3]:
- index 0 is the control word;
- index 1 is a reserved word that reads as zero;
- index 2 is the status word;
- index 3 is the data word.

A control word whose byte count exceeds four is dropped. A control word that arrives while a transfer is still running is also dropped.

Top module: `cmd_bus_bridge`

## Requirements
- R1: Only register accesses with `reg_size` equal to 8 are acted on. A write of any other size changes nothing. A read of any other size returns zero with `reg_rvalid`, and it does not clear the status register.
- R2: The register index is `reg_addr[4:3]` and the other address bits are ignored. Index 0 (control) and index 1 (reserved) read as zero, and writes to index 1 have no effect.
- R3: A write to index 3 loads the data register from `reg_wdata[63:32]`. Reading index 3 returns the data register in bits 63:32 with zeros in bits 31:0.
- R4: A control write (index 0) is decoded as follows: bit 48 is the read flag, bits 59:56 are the byte count and bits 31:0 are the bus address. From the next cycle the bridge holds `bus_req` high, with `bus_we` equal to the inverse of the read flag, `bus_size` equal to the byte count and `bus_addr` equal to the address. These values stay stable until a cycle in which `bus_ready` or `bus_err` is high.
- R5: A control word with a byte count greater than 4 starts no bus cycle and leaves the status register unchanged.
- R6: When a read completes with `bus_ready`, the status register becomes bit 11 set, with `bus_rdata` in bits 57:26 (first byte in bits 57:50) and all other bits zero.
- R7: When a read completes with `bus_err`, the status register becomes bit 11 set with all ones in bits 57:26.
- R8: A write drives `bus_wdata` with the data register as it was when the control word was accepted. Its most significant byte goes first, in bits 31:24. Completion sets the status register to bit 11 alone, whether the bus returns ready or error.
- R9: An 8-byte read of index 2 returns the status value, and the status register is zero afterwards. This holds unless a transfer completes in that same cycle.
- R10: A control write that arrives while `bus_req` is high is ignored. The running transfer keeps its address, size and direction, and no second transfer follows.
- R11: After reset `bus_req` and `reg_rvalid` are low and the status, data and control state are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_req | input | 1 | Register access strobe, one cycle per access |
| reg_we | input | 1 | 1 for a register write, 0 for a read |
| reg_addr | input | ADDR_W | Register byte address; bits [4:3] select the register |
| reg_size | input | 4 | Access size in bytes; only 8 is accepted |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | High the cycle after a register read |
| bus_req | output | 1 | Peripheral bus request, held until ready or error |
| bus_we | output | 1 | 1 for a bus write |
| bus_addr | output | 32 | Bus address |
| bus_size | output | 3 | Bus transfer byte count (0 to 4) |
| bus_wdata | output | 32 | Bus write data, first byte in bits 31:24 |
| bus_rdata | input | 32 | Bus read data, first byte in bits 31:24 |
| bus_ready | input | 1 | Bus completes the transfer successfully |
| bus_err | input | 1 | Bus completes the transfer with an error |

## Verification
The bench sweeps every byte count from 0 to 7, crossed with both directions and both bus responses. It changes the address, the read data and the write data on every pass. This separates each of the following cases:
- counts that are accepted from counts that are rejected;
- the packed read result from the all-ones result after an error;
- writes, whose status ignores the response, from reads.

Each pass also sends a rejected control word after completion and reads the status twice. This distinguishes "unchanged" from "cleared on read". Separate cases cover:
- a second control word sent while a transfer is running;
- accesses that are not 8 bytes wide;
- aliased high address bits;
- the reserved index.

// File: rtl/cmd_bus_bridge.sv
module cmd_bus_bridge #(
  parameter int ADDR_W    = 8,
  parameter int MAX_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_req,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [3:0]        reg_size,
  input  logic [63:0]       reg_wdata,
  output logic [63:0]       reg_rdata,
  output logic              reg_rvalid,
  output logic              bus_req,
  output logic              bus_we,
  output logic [31:0]       bus_addr,
  output logic [2:0]        bus_size,
  output logic [31:0]       bus_wdata,
  input  logic [31:0]       bus_rdata,
  input  logic              bus_ready,
  input  logic              bus_err
);
  localparam int RD_FLAG  = 48;
  localparam int CNT_LO   = 56;
  localparam int DONE_BIT = 11;
  localparam int DATA_LO  = 26;
  localparam logic [1:0] IDX_CTL = 2'd0, IDX_STAT = 2'd2, IDX_DATA = 2'd3;

  logic [31:0] data_q, wdata_q, addr_q;
  logic [63:0] stat_q;
  logic [3:0]  cnt_q;
  logic        rd_q, busy_q;

  wire [1:0] idx     = reg_addr[4:3];
  wire       acc     = reg_req && (reg_size == 4'd8);
  wire [3:0] new_cnt = reg_wdata[CNT_LO+3:CNT_LO];
  wire       launch  = acc && reg_we && idx == IDX_CTL && !busy_q && (new_cnt <= 4'(MAX_BYTES));
  wire       finish  = busy_q && (bus_ready || bus_err);
  wire       stat_rd = acc && !reg_we && idx == IDX_STAT;
  wire [31:0] rd_val = bus_err ? 32'hFFFF_FFFF : bus_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q     <= '0;
      wdata_q    <= '0;
      addr_q     <= '0;
      stat_q     <= '0;
      cnt_q      <= '0;
      rd_q       <= 1'b0;
      busy_q     <= 1'b0;
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      if (launch) begin
        busy_q  <= 1'b1;
        addr_q  <= reg_wdata[31:0];
        cnt_q   <= new_cnt;
        rd_q    <= reg_wdata[RD_FLAG];
        wdata_q <= data_q;
      end else if (finish) begin
        busy_q <= 1'b0;
      end
      if (acc && reg_we && idx == IDX_DATA)
        data_q <= reg_wdata[63:32];
      if (finish)
        stat_q <= rd_q ? ((64'(1) << DONE_BIT) | (64'(rd_val) << DATA_LO))
                       : (64'(1) << DONE_BIT);
      else if (stat_rd)
        stat_q <= '0;
      reg_rvalid <= reg_req && !reg_we;
      if (reg_req && !reg_we) begin
        if (!acc)                 reg_rdata <= '0;
        else if (idx == IDX_STAT) reg_rdata <= stat_q;
        else if (idx == IDX_DATA) reg_rdata <= {data_q, 32'd0};
        else                      reg_rdata <= '0;
      end
    end
  end

  assign bus_req   = busy_q;
  assign bus_we    = !rd_q;
  assign bus_addr  = addr_q;
  assign bus_size  = cnt_q[2:0];
  assign bus_wdata = wdata_q;

  assert_rvalid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req && !reg_we |=> reg_rvalid);

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !(bus_ready || bus_err) |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_size));

  assert_size_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> bus_size <= 3'(MAX_BYTES));

  assert_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && (bus_ready || bus_err) |=> stat_q[DONE_BIT]);

  assert_err_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_err && !bus_we |=> stat_q[57:26] == 32'hFFFF_FFFF);

  assert_write_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we && (bus_ready || bus_err) |=> stat_q == 64'h800);

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && !(bus_req && (bus_ready || bus_err)) |=> stat_q == 64'd0);

  assert_ignore_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req && reg_we && bus_req && !(bus_ready || bus_err) |=> $stable(bus_addr) && $stable(bus_size));
endmodule

// File: tb/cmd_bus_bridge_test.sv
module cmd_bus_bridge_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        reg_req = 0, reg_we = 0;
  logic [7:0]  reg_addr = 0;
  logic [3:0]  reg_size = 0;
  logic [63:0] reg_wdata = 0, reg_rdata;
  logic        reg_rvalid;
  logic        bus_req, bus_we;
  logic [31:0] bus_addr, bus_wdata;
  logic [2:0]  bus_size;
  logic [31:0] bus_rdata = 0;
  logic        bus_ready = 0, bus_err = 0;

  int checks = 0, errors = 0;

  cmd_bus_bridge uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] idx, input logic [63:0] d, input logic [3:0] sz);
    @(negedge clk);
    reg_req = 1; reg_we = 1; reg_addr = {3'b0, idx, 3'b0}; reg_size = sz; reg_wdata = d;
    @(negedge clk);
    reg_req = 0; reg_we = 0;
  endtask

  task automatic reg_rd(input logic [7:0] a, input logic [3:0] sz, output logic [63:0] d);
    @(negedge clk);
    reg_req = 1; reg_we = 0; reg_addr = a; reg_size = sz;
    @(negedge clk);
    reg_req = 0;
    chk("R1 rvalid", {63'd0, reg_rvalid}, 64'd1);
    d = reg_rdata;
  endtask

  task automatic bus_done(input logic err, input logic [31:0] rd);
    bus_ready = !err; bus_err = err; bus_rdata = rd;
    @(negedge clk);
    bus_ready = 0; bus_err = 0;
  endtask

  function automatic logic [63:0] ctl(input logic rd, input logic [3:0] cnt, input logic [31:0] a);
    return {4'b0, cnt, 7'b0, rd, 16'b0, a};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [63:0] d, exp_stat;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 bus_req", {63'd0, bus_req}, 64'd0);
    chk("R11 rvalid", {63'd0, reg_rvalid}, 64'd0);
    rst_n = 1;
    reg_rd(8'h10, 4'd8, d); chk("R11 status", d, 64'd0);
    reg_rd(8'h18, 4'd8, d); chk("R11 data", d, 64'd0);

    // R3 data register load and readback, R2 aliasing of high address bits
    reg_wr(2'd3, 64'hDEAD_BEEF_1234_5678, 4'd8);
    reg_rd(8'h18, 4'd8, d); chk("R3 data readback", d, 64'hDEAD_BEEF_0000_0000);
    reg_rd(8'hF8, 4'd8, d); chk("R2 alias idx3", d, 64'hDEAD_BEEF_0000_0000);
    reg_rd(8'h00, 4'd8, d); chk("R2 ctl reads zero", d, 64'd0);
    reg_wr(2'd1, 64'hFFFF_FFFF_FFFF_FFFF, 4'd8);
    reg_rd(8'h08, 4'd8, d); chk("R2 reserved reads zero", d, 64'd0);
    reg_rd(8'h18, 4'd8, d); chk("R2 reserved write no effect", d, 64'hDEAD_BEEF_0000_0000);
    // R1 wrong-size accesses
    reg_wr(2'd3, 64'h1111_2222_0000_0000, 4'd4);
    reg_rd(8'h18, 4'd8, d); chk("R1 size4 write ignored", d, 64'hDEAD_BEEF_0000_0000);
    reg_wr(2'd0, ctl(1'b1, 4'd4, 32'h40), 4'd4);
    chk("R1 size4 ctl ignored", {63'd0, bus_req}, 64'd0);

    exp_stat = 0;
    for (int i = 0; i < 32; i++) begin
      logic [3:0]  cnt = 4'(i % 8);
      logic        rd  = i[3];
      logic        err = i[4];
      logic [31:0] a   = 32'h1000_0000 + 32'(i) * 32'h0001_0103;
      logic [31:0] wd  = 32'hC0DE_0000 ^ (32'(i) * 32'h0123_4567);
      logic [31:0] rv  = 32'hA500_0000 ^ (32'(i) * 32'h0765_4321);
      reg_wr(2'd3, {wd, 32'h5555_5555}, 4'd8);
      reg_wr(2'd0, ctl(rd, cnt, a), 4'd8);
      if (cnt <= 4) begin
        chk("R4 bus_req", {63'd0, bus_req}, 64'd1);
        chk("R4 bus_addr", {32'd0, bus_addr}, {32'd0, a});
        chk("R4 bus_we", {63'd0, bus_we}, {63'd0, !rd});
        chk("R4 bus_size", {61'd0, bus_size}, {61'd0, cnt[2:0]});
        if (!rd) chk("R8 bus_wdata", {32'd0, bus_wdata}, {32'd0, wd});
        @(negedge clk);
        chk("R4 held", {32'd0, bus_addr}, {32'd0, a});
        bus_done(err, rv);
        chk("R4 released", {63'd0, bus_req}, 64'd0);
        if (!rd)      exp_stat = 64'h800;
        else if (err) exp_stat = 64'h800 | (64'hFFFF_FFFF << 26);
        else          exp_stat = 64'h800 | (64'(rv) << 26);
      end else begin
        chk("R5 no bus cycle", {63'd0, bus_req}, 64'd0);
      end
      reg_wr(2'd0, ctl(1'b1, 4'd7, 32'hBAD), 4'd8);
      chk("R5 rejected ctl", {63'd0, bus_req}, 64'd0);
      reg_rd(8'h10, 4'd4, d); chk("R1 size4 read zero", d, 64'd0);
      reg_rd(8'h10, 4'd8, d);
      chk(!rd ? "R8 write status" : (err ? "R7 error status" : "R6 read status"), d, exp_stat);
      reg_rd(8'h10, 4'd8, d); chk("R9 cleared on read", d, 64'd0);
      exp_stat = 0;
    end

    // R10 control write while busy
    reg_wr(2'd0, ctl(1'b1, 4'd2, 32'h0000_ABCD), 4'd8);
    reg_wr(2'd0, ctl(1'b0, 4'd1, 32'h0000_1111), 4'd8);
    chk("R10 addr kept", {32'd0, bus_addr}, 64'h0000_ABCD);
    chk("R10 size kept", {61'd0, bus_size}, 64'd2);
    chk("R10 dir kept", {63'd0, bus_we}, 64'd0);
    bus_done(1'b0, 32'h0102_0304);
    @(negedge clk);
    chk("R10 no second cycle", {63'd0, bus_req}, 64'd0);
    reg_rd(8'h10, 4'd8, d);
    chk("R10 status of first", d, 64'h800 | (64'h0102_0304 << 26));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule